// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block is a multicycle arithmetic engine for an 8-bit datapath that keeps a 16-bit value in a split register pair: a low byte (the accumulator, A) and a high byte (Y), with an 8-bit index operand (X) next to them. It does two things. A multiply forms the unsigned product Y*A and writes it back across the pair, with the low byte going to A and the high byte going to Y. A divide takes the pair as a 16-bit dividend, divides it by X, and writes the quotient to A and the remainder to Y.

The host raises a one-cycle start strobe along with an operation select and the operands. The unit latches them, raises busy, and runs a shift-add or shift-subtract loop of one bit per clock. It then raises done for one clock, after a fixed count of clocks that depends on the operation. The results and the condition flags (negative, overflow, half-carry, zero) are registered, and they hold until the next operation completes. A divide whose quotient cannot fit in eight bits (this includes division by zero) gives a defined saturated result and never stalls.

Top module: `pair_muldiv`

## Requirements
- R1: With op_div_i = 0, the unit computes the unsigned 16-bit product of y_i and a_i. It puts the low byte on a_o and the high byte on y_o.
- R2: After a multiply, n_o is bit 7 of y_o and z_o is 1 exactly when y_o is zero. v_o and h_o take the values of v_i and h_i that were sampled with the start strobe.
- R3: With op_div_i = 1, x_i nonzero and y_i < x_i, a_o is the quotient of {y_i,a_i} / x_i and y_o is the remainder, and v_o is 0.
- R4: When x_i is zero or y_i >= x_i, the divide sets v_o to 1 and a_o to 8'hFF. y_o becomes the low byte of {y_i,a_i} minus 255*x_i, which equals (a_i + x_i) mod 256.
- R5: After a divide, h_o is 1 exactly when x_i[3:0] <= y_i[3:0], using the input values.
- R6: After a divide, n_o is bit 7 of a_o and z_o is 1 exactly when a_o is zero.
- R7: done_o rises exactly 9 clock edges (multiply) or 12 clock edges (divide) after the edge that accepts start_i. busy_o is high from the accepting edge until the edge that raises done_o, and it is low while done_o is high.
- R8: done_o is high for exactly one cycle per operation. a_o, y_o and the flags change only at the edge that raises done_o, and they hold in all other cycles.
- R9: A start_i strobe seen while busy_o is high is ignored. The running operation keeps its operands, its operation and its timing, and no extra done_o pulse appears.
- R10: After a synchronous active-low reset, busy_o, done_o, a_o, y_o and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when busy_o is low |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| a_i | input | 8 | Low byte of the pair (multiplicand A / dividend low) |
| y_i | input | 8 | High byte of the pair (multiplier Y / dividend high) |
| x_i | input | 8 | Divisor |
| v_i | input | 1 | Current overflow flag, passed through by multiply |
| h_i | input | 1 | Current half-carry flag, passed through by multiply |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 8 | Result low byte (product low / quotient) |
| y_o | output | 8 | Result high byte (product high / remainder) |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| h_o | output | 1 | Half-carry flag |
| z_o | output | 1 | Zero flag |

## Verification
The hardest situation to reach is the border between a normal divide and a saturated one. A quotient of exactly 255 is in range, while a high byte equal to the divisor is already saturated. Random operands almost never land on either side of that line. The stimulus therefore drives directed operands with y_i = x_i - 1 and y_i = x_i, plus x_i = 0 and x_i = 1. It also raises start strobes in the middle of a running operation, carrying different operands, to show that the latched operation ends unchanged and on time.

// File: rtl/pair_muldiv_pkg.sv
// Package: shared types for the iterative multiply-divide unit.
// Assumes: operation select is a single bit from the host.
package pair_muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
    } md_flags_t;

endpackage

// File: rtl/pair_muldiv_seq.sv
// Module: pair_muldiv_seq
// Counts clocks for one operation. It accepts a start strobe only when idle,
// issues one iteration enable per clock for the first STEPS clocks, and
// pulses finish on the clock that matches the latency of the latched operation.
// Assumes: MUL_LAT and DIV_LAT are both greater than STEPS.
module pair_muldiv_seq
    import pair_muldiv_pkg::*;
#(
    parameter int MUL_LAT = 9,
    parameter int DIV_LAT = 12,
    parameter int STEPS   = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  md_op_e op_i,
    output logic   load_o,
    output logic   step_o,
    output logic   finish_o,
    output logic   busy_o,
    output logic   done_o,
    output md_op_e op_o
);

    localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    md_op_e        op_q;
    logic [CW-1:0] lat_sel;

    // Latency of the operation in flight, and the control strobes.
    always_comb begin
        lat_sel  = (op_q == OP_DIV) ? CW'(DIV_LAT) : CW'(MUL_LAT);
        load_o   = start_i && !busy_q;
        step_o   = busy_q && (cnt_q <= CW'(STEPS));
        finish_o = busy_q && (cnt_q == lat_sel);
    end

    // Busy/counter/operation state and the registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_MUL;
        end else begin
            done_q <= finish_o;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(1);
                op_q   <= op_i;
            end else if (finish_o) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q  <= cnt_q + CW'(1);
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign op_o   = op_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0) && (cnt_q <= lat_sel));

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !finish_o) |=> busy_q && (op_q == $past(op_q)));

endmodule

// File: rtl/pair_muldiv_mul.sv
// Module: pair_muldiv_mul
// Radix-2 shift-add multiplier. It takes one multiplier bit per step, so after
// W steps the product register holds the full 2W-bit product.
// Assumes: step_i is never high in the same cycle as load_i.
module pair_muldiv_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   lo_i,
    input  logic [W-1:0]   hi_i,
    output logic [2*W-1:0] prod_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;

    // Accumulate the shifted multiplicand for each set multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            acc_q    <= '0;
            mcand_q  <= {{W{1'b0}}, hi_i};
            mplier_q <= lo_i;
        end else if (step_i) begin
            if (mplier_q[0]) begin
                acc_q <= acc_q + mcand_q;
            end
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign prod_o = acc_q;

    // R1: once every multiplier bit is used up, the product stops changing
    mul_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (mplier_q == '0)) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/pair_muldiv_div.sv
// Module: pair_muldiv_div
// Restoring shift-subtract divider. It produces one quotient bit per step from
// the low dividend byte while the partial remainder starts from the high byte.
// Assumes: the result is meaningful only when hi < divisor; the result unit
// overrides it otherwise.
module pair_muldiv_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvsr_q;
    logic         fits_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         take;

    // One restoring step: shift in the next dividend bit, then try the subtract.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dvsr_q};
        take  = (trial >= {1'b0, dvsr_q});
    end

    // Partial remainder, quotient shift register and latched divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
            fits_q <= 1'b0;
        end else if (load_i) begin
            rem_q  <= hi_i;
            quo_q  <= lo_i;
            dvsr_q <= dvsr_i;
            fits_q <= (hi_i < dvsr_i);
        end else if (step_i) begin
            rem_q <= take ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], take};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // R3: in the non-saturating case the partial remainder stays below the divisor
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fits_q && step_i) |=> (rem_q < dvsr_q));

endmodule

// File: rtl/pair_muldiv_result.sv
// Module: pair_muldiv_result
// Combinational finishing stage. It picks the product or the quotient and
// remainder, applies divide saturation, and forms the four condition flags.
// Assumes: operand inputs are the values latched at start.
module pair_muldiv_result
    import pair_muldiv_pkg::*;
#(
    parameter int W = 8
) (
    input  md_op_e         op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   y_i,
    input  logic [W-1:0]   x_i,
    input  logic           v_i,
    input  logic           h_i,
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   quo_i,
    input  logic [W-1:0]   rem_i,
    output logic [W-1:0]   a_o,
    output logic [W-1:0]   y_o,
    output md_flags_t      flags_o
);

    localparam int HW = W / 2;

    logic sat;

    // Select the results and derive the flags for the finished operation.
    always_comb begin
        sat = (x_i == '0) || (y_i >= x_i);
        if (op_i == OP_DIV) begin
            if (sat) begin
                a_o = '1;
                y_o = a_i + x_i;
            end else begin
                a_o = quo_i;
                y_o = rem_i;
            end
            flags_o.n = a_o[W-1];
            flags_o.z = (a_o == '0);
            flags_o.v = sat;
            flags_o.h = (x_i[HW-1:0] <= y_i[HW-1:0]);
        end else begin
            a_o       = prod_i[W-1:0];
            y_o       = prod_i[2*W-1:W];
            flags_o.n = y_o[W-1];
            flags_o.z = (y_o == '0);
            flags_o.v = v_i;
            flags_o.h = h_i;
        end
    end

endmodule

// File: rtl/pair_muldiv.sv
// Module: pair_muldiv
// Top of the iterative multiply-divide unit. It latches operands on an
// accepted start, runs the multiplier and divider cores side by side under
// the sequencer, and registers the results and flags on the finishing clock.
// Assumes: the host samples a_o/y_o/flags when done_o is high or later.
module pair_muldiv
    import pair_muldiv_pkg::*;
#(
    parameter int W       = 8,
    parameter int MUL_LAT = 9,
    parameter int DIV_LAT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_div_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] x_i,
    input  logic         v_i,
    input  logic         h_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] y_o,
    output logic         n_o,
    output logic         v_o,
    output logic         h_o,
    output logic         z_o
);

    logic           load;
    logic           step;
    logic           finish;
    md_op_e         op_req;
    md_op_e         op_q;
    logic [W-1:0]   a_q;
    logic [W-1:0]   y_q;
    logic [W-1:0]   x_q;
    logic           v_q;
    logic           h_q;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic [W-1:0]   res_a;
    logic [W-1:0]   res_y;
    md_flags_t      res_flags;
    logic [W-1:0]   out_a_q;
    logic [W-1:0]   out_y_q;
    md_flags_t      out_flags_q;

    assign op_req = op_div_i ? OP_DIV : OP_MUL;

    pair_muldiv_seq #(
        .MUL_LAT(MUL_LAT),
        .DIV_LAT(DIV_LAT),
        .STEPS  (W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_req),
        .load_o  (load),
        .step_o  (step),
        .finish_o(finish),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .op_o    (op_q)
    );

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            y_q <= '0;
            x_q <= '0;
            v_q <= 1'b0;
            h_q <= 1'b0;
        end else if (load) begin
            a_q <= a_i;
            y_q <= y_i;
            x_q <= x_i;
            v_q <= v_i;
            h_q <= h_i;
        end
    end

    pair_muldiv_mul #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .step_i(step),
        .lo_i  (a_i),
        .hi_i  (y_i),
        .prod_o(prod)
    );

    pair_muldiv_div #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .step_i(step),
        .lo_i  (a_i),
        .hi_i  (y_i),
        .dvsr_i(x_i),
        .quo_o (quo),
        .rem_o (rem)
    );

    pair_muldiv_result #(.W(W)) u_res (
        .op_i   (op_q),
        .a_i    (a_q),
        .y_i    (y_q),
        .x_i    (x_q),
        .v_i    (v_q),
        .h_i    (h_q),
        .prod_i (prod),
        .quo_i  (quo),
        .rem_i  (rem),
        .a_o    (res_a),
        .y_o    (res_y),
        .flags_o(res_flags)
    );

    // Result registers, loaded only on the finishing clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a_q     <= '0;
            out_y_q     <= '0;
            out_flags_q <= '0;
        end else if (finish) begin
            out_a_q     <= res_a;
            out_y_q     <= res_y;
            out_flags_q <= res_flags;
        end
    end

    assign a_o = out_a_q;
    assign y_o = out_y_q;
    assign n_o = out_flags_q.n;
    assign v_o = out_flags_q.v;
    assign h_o = out_flags_q.h;
    assign z_o = out_flags_q.z;

    // R4
    div_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_q == OP_DIV) && v_o) |-> (a_o == '1));

    // R2
    mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_q == OP_MUL)) |-> (z_o == (y_o == '0)) && (n_o == y_o[W-1]));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({a_o, y_o, n_o, v_o, h_o, z_o}));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

endmodule

// File: tb/test_pair_muldiv.sv
module test_pair_muldiv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_div_i = 1'b0;
    logic [7:0] a_i = '0, y_i = '0, x_i = '0;
    logic       v_i = 1'b0, h_i = 1'b0;
    logic       busy_o, done_o, n_o, v_o, h_o, z_o;
    logic [7:0] a_o, y_o;

    pair_muldiv i_pair_muldiv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
        .a_i(a_i), .y_i(y_i), .x_i(x_i), .v_i(v_i), .h_i(h_i),
        .busy_o(busy_o), .done_o(done_o), .a_o(a_o), .y_o(y_o),
        .n_o(n_o), .v_o(v_o), .h_o(h_o), .z_o(z_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [7:0] a;
        logic [7:0] y;
        logic       n, v, h, z;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    logic [7:0] last_a = '0, last_y = '0;
    logic prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model built from the requirements.
    function automatic exp_t model(logic op, logic [7:0] a, logic [7:0] y,
                                   logic [7:0] x, logic v, logic h);
        exp_t e;
        logic [15:0] p;
        if (!op) begin
            p = 16'(y) * 16'(a);
            e.a = p[7:0]; e.y = p[15:8];
            e.n = e.y[7]; e.z = (e.y == 0); e.v = v; e.h = h;
            e.tag = "R1/R2";
        end else begin
            if (x == 0 || y >= x) begin
                e.a = 8'hFF; e.y = a + x; e.v = 1'b1; e.tag = "R4/R5/R6";
            end else begin
                e.a = 8'({y, a} / 16'(x)); e.y = 8'({y, a} % 16'(x));
                e.v = 1'b0; e.tag = "R3/R5/R6";
            end
            e.h = (x[3:0] <= y[3:0]);
            e.n = e.a[7]; e.z = (e.a == 0);
        end
        return e;
    endfunction

    // Driver: wait until idle, issue one operation, push its expectation.
    task automatic run_op(logic op, logic [7:0] a, logic [7:0] y, logic [7:0] x,
                          logic v, logic h);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        op_div_i = op; a_i = a; y_i = y; x_i = x; v_i = v; h_i = h;
        start_i = 1'b1;
        e = model(op, a, y, x, v, h);
        e.cyc = cyc + 1 + (op ? 12 : 9);
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each completion with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done_o) begin
                checks++; fails++;
                $display("FAIL R8 done high two cycles: actual 1 expected 0");
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9 unexpected done: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (a_o !== e.a || y_o !== e.y || n_o !== e.n || v_o !== e.v ||
                        h_o !== e.h || z_o !== e.z) begin
                        fails++;
                        $display("FAIL %s actual a=%h y=%h nvhz=%b%b%b%b expected a=%h y=%h nvhz=%b%b%b%b",
                                 e.tag, a_o, y_o, n_o, v_o, h_o, z_o,
                                 e.a, e.y, e.n, e.v, e.h, e.z);
                    end
                    checks++;
                    if (cyc != e.cyc) begin
                        fails++;
                        $display("FAIL R7 done cycle actual %0d expected %0d", cyc, e.cyc);
                    end
                    last_a = e.a; last_y = e.y;
                end
            end
            prev_done = done_o;
        end
    end

    // Watchdog.
    initial begin
        #(5 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        checks++;
        if ({busy_o, done_o, a_o, y_o, n_o, v_o, h_o, z_o} !== '0) begin
            fails++;
            $display("FAIL R10 reset state actual %h expected 0",
                     {busy_o, done_o, a_o, y_o, n_o, v_o, h_o, z_o});
        end
        rst_n = 1'b1;

        // R1 R2: multiply corners
        run_op(1'b0, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0);
        run_op(1'b0, 8'h00, 8'h7B, 8'h00, 1'b0, 1'b1);
        run_op(1'b0, 8'h80, 8'h02, 8'h00, 1'b1, 1'b1);
        run_op(1'b0, 8'h10, 8'h10, 8'h00, 1'b0, 1'b0);

        // R7: busy high right after acceptance
        run_op(1'b1, 8'h34, 8'h12, 8'h56, 1'b0, 1'b0);
        checks++;
        if (busy_o !== 1'b1) begin
            fails++;
            $display("FAIL R7 busy after start actual %b expected 1", busy_o);
        end

        // R3 R4 R5 R6: divide boundaries
        run_op(1'b1, 8'h55, 8'h12, 8'h00, 1'b0, 1'b0);
        run_op(1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        run_op(1'b1, 8'hAB, 8'h00, 8'h01, 1'b0, 1'b0);
        run_op(1'b1, 8'hAB, 8'h01, 8'h01, 1'b0, 1'b0);
        run_op(1'b1, 8'hFF, 8'h3F, 8'h40, 1'b0, 1'b0);
        run_op(1'b1, 8'h00, 8'h40, 8'h40, 1'b0, 1'b0);
        run_op(1'b1, 8'hFF, 8'hFE, 8'hFF, 1'b0, 1'b0);
        run_op(1'b1, 8'h00, 8'h00, 8'h05, 1'b0, 1'b0);
        run_op(1'b1, 8'h07, 8'h00, 8'h09, 1'b0, 1'b0);

        // R9: strobes during a running multiply are ignored
        run_op(1'b0, 8'h0C, 8'h0B, 8'h00, 1'b0, 1'b0);
        op_div_i = 1'b1; a_i = 8'h99; y_i = 8'h99; x_i = 8'h00; start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        checks++;
        if (busy_o !== 1'b1) begin
            fails++;
            $display("FAIL R9 busy during ignored strobe actual %b expected 1", busy_o);
        end
        wait_drain();

        // R8: results hold after done
        repeat (6) @(negedge clk);
        checks++;
        if (a_o !== last_a || y_o !== last_y || done_o !== 1'b0) begin
            fails++;
            $display("FAIL R8 hold actual a=%h y=%h done=%b expected a=%h y=%h done=0",
                     a_o, y_o, done_o, last_a, last_y);
        end

        // R1 R3 R4: randomised operands
        for (int i = 0; i < 300; i++) begin
            logic [7:0] ra, ry, rx;
            ra = 8'($urandom); ry = 8'($urandom); rx = 8'($urandom);
            if (i % 3 == 0) ry = rx - 8'($urandom_range(1, 3));
            run_op(1'($urandom), ra, ry, rx, 1'($urandom), 1'($urandom));
        end
        wait_drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule